// File: doc/BRIEF.md
# Triple-Redundant Configuration Register File

This block holds 32 configuration words of 16 bits. Every word is kept in three independent copies (A, B and C). The read port and a flat bus of always-visible configuration outputs both show the bitwise two-of-three vote of the copies. A single upset bit in one copy is therefore never seen by the logic that consumes the configuration.

Writes go through a short sequencer. An accepted write registers its address and data. It then loads copy A, copy B and copy C on three separate, consecutive clock cycles. A transient on one load path can only disturb one copy, and the other two outvote it. The address is decoded into one-hot line selects. A line loads when its select and the current copy strobe are both active. It drives the read bus when its select is active and the write enable is low.

While the block is idle, a background scrubber visits one address per clock. Where a copy differs from the majority, the scrubber rewrites that copy and raises a one-cycle repair flag. A test input can overwrite one bit of one copy, so that the hardening can be exercised from the ports.

Top module: `tmr_cfg_regfile`

## Requirements
- R1: While reset is asserted and after it is released, all words read as zero, `cfgOut` is zero, `busy` is low and `scrubFix` is low.
- R2: `wrEn` high while `busy` is low is accepted at that clock edge. `busy` is then high for exactly three cycles. `wrEn` while `busy` is high is ignored, and the addressed word keeps its value.
- R3: An accepted write loads copy A one cycle after acceptance, copy B two cycles after and copy C three cycles after. At most one copy strobe is active per cycle. The voted word stays old one cycle after acceptance and shows the new data two cycles after.
- R4: When `wrEn` is low, `rdData` is the voted word at `wrAddr`. When `wrEn` is high, `rdData` is all zeros.
- R5: `cfgOut[16*i+15:16*i]` is the voted value of word i, for every i from 0 to 31.
- R6: `injEn` overwrites, at the clock edge, bit `injBit` of one copy of word `wrAddr` with `wrData[injBit]`. `injCopy` selects the copy: 0 is A, 1 is B, 2 is C, and 3 selects no copy. A single such upset leaves `rdData` and `cfgOut` unchanged.
- R7: The scrubber runs in each cycle that is idle with `wrEn` low. It starts at address 0 after reset, advances by one per such cycle and wraps from 31 to 0. It rewrites a disagreeing copy from the majority, and `scrubFix` is high in the cycle after each repair. A repaired copy then outvotes a later upset of another copy in the same bit.
- R8: The scrubber is paused for the acceptance cycle and the three load cycles of a write, so a clean write never causes a `scrubFix` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write request; also disables the read bus |
| wrAddr | input | 5 | Word address for write, read and injection |
| wrData | input | 16 | Write data; also the injection source |
| rdData | output | 16 | Voted word at `wrAddr`, zero while `wrEn` is high |
| busy | output | 1 | Write sequence in progress |
| cfgOut | output | 512 | All 32 voted words, word i at bits 16*i+15:16*i |
| scrubFix | output | 1 | One-cycle pulse after the scrubber repairs a copy |
| injEn | input | 1 | Test upset enable |
| injCopy | input | 2 | Copy to upset (0 A, 1 B, 2 C, 3 none) |
| injBit | input | 4 | Bit position to upset |

## Verification
The bench samples the voted word on each cycle of a write. A design that loads all copies together, or votes the wrong way, would show new data one cycle too early. It drives a write while busy and then reads the target word. A sequencer that takes the write would change that word. It releases reset with an upset already pending at address 1 and expects the repair pulse exactly one cycle later. A scrubber that starts elsewhere, or steps wrongly, would miss that cycle. It then upsets a second copy in the same bit after the first repair. A scrubber that does not really rewrite the copy lets the vote flip. A scrubber that runs during the load sequence would raise a repair pulse after a clean write.

// File: rtl/tmrCfgPkg.sv
package tmrCfgPkg;

  localparam int NCOPY = 3;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_LDA  = 2'd1,
    SEQ_LDB  = 2'd2,
    SEQ_LDC  = 2'd3
  } seqStateT;

  // strobes from control to datapath
  typedef struct packed {
    logic [NCOPY-1:0] copyLoad;  // bit 0 = copy A, bit 1 = B, bit 2 = C
    logic             scrubEn;
  } ctrlStrobeT;

endpackage

// File: rtl/tmrCfgCtrl.sv
module tmrCfgCtrl
  import tmrCfgPkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              scrubMismatch,
  output ctrlStrobeT        strobe,
  output logic [ADDR_W-1:0] loadAddr,
  output logic [DATA_W-1:0] loadData,
  output logic [ADDR_W-1:0] scrubAddr,
  output logic              busy,
  output logic              scrubFix
);

  seqStateT          state;
  logic [ADDR_W-1:0] scrubPtr;

  always_comb begin
    strobe.copyLoad = {state == SEQ_LDC, state == SEQ_LDB, state == SEQ_LDA};
    strobe.scrubEn  = (state == SEQ_IDLE) && !wrEn;
  end

  assign busy      = (state != SEQ_IDLE);
  assign scrubAddr = scrubPtr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= SEQ_IDLE;
      loadAddr <= '0;
      loadData <= '0;
      scrubPtr <= '0;
      scrubFix <= 1'b0;
    end else begin
      unique case (state)
        SEQ_IDLE: begin
          if (wrEn) begin
            state    <= SEQ_LDA;
            loadAddr <= wrAddr;
            loadData <= wrData;
          end
        end
        SEQ_LDA: state <= SEQ_LDB;
        SEQ_LDB: state <= SEQ_LDC;
        SEQ_LDC: state <= SEQ_IDLE;
        default: state <= SEQ_IDLE;
      endcase
      if (strobe.scrubEn) scrubPtr <= scrubPtr + 1'b1;
      scrubFix <= strobe.scrubEn && scrubMismatch;
    end
  end

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && wrEn) |=> busy);

  // R2
  busy_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(strobe.copyLoad[2]));

  // R3
  stagger_ab_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.copyLoad[0] |=> strobe.copyLoad[1]);

  // R3
  stagger_bc_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.copyLoad[1] |=> strobe.copyLoad[2]);

  // R3
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe.copyLoad));

  // R8
  no_scrub_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !strobe.scrubEn);

  // R7
  scrub_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.scrubEn |=> (scrubAddr == ADDR_W'($past(scrubAddr) + 1'b1)));

endmodule

// File: rtl/tmrCfgDatapath.sv
module tmrCfgDatapath
  import tmrCfgPkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 32,
  parameter int BIT_W  = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctrlStrobeT                strobe,
  input  logic [ADDR_W-1:0]         loadAddr,
  input  logic [DATA_W-1:0]         loadData,
  input  logic [ADDR_W-1:0]         scrubAddr,
  input  logic [ADDR_W-1:0]         rdAddr,
  input  logic                      wrEn,
  input  logic                      injEn,
  input  logic [1:0]                injCopy,
  input  logic [BIT_W-1:0]          injBit,
  input  logic [DATA_W-1:0]         injData,
  output logic [DATA_W-1:0]         rdData,
  output logic [DEPTH*DATA_W-1:0]   cfgOut,
  output logic                      scrubMismatch
);

  logic [DEPTH-1:0]              loadLine;
  logic [DEPTH-1:0]              readLine;
  logic [DEPTH-1:0][DATA_W-1:0]  copyWord [NCOPY];
  logic [DEPTH-1:0][DATA_W-1:0]  voteWord;
  logic [NCOPY-1:0]              needFix;

  // one-hot line decode; read enable is select and not write enable
  for (genvar i = 0; i < DEPTH; i++) begin : g_line
    assign loadLine[i] = (loadAddr == ADDR_W'(i));
    assign readLine[i] = (rdAddr == ADDR_W'(i)) & ~wrEn;
    assign voteWord[i] = (copyWord[0][i] & copyWord[1][i]) |
                         (copyWord[0][i] & copyWord[2][i]) |
                         (copyWord[1][i] & copyWord[2][i]);
  end

  // each copy has its own storage and its own load strobe
  for (genvar c = 0; c < NCOPY; c++) begin : g_copy
    logic [DEPTH-1:0][DATA_W-1:0] cells;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cells <= '0;
      end else begin
        for (int i = 0; i < DEPTH; i++) begin
          if (loadLine[i] && strobe.copyLoad[c]) begin
            cells[i] <= loadData;
          end else if (strobe.scrubEn && needFix[c] && (scrubAddr == ADDR_W'(i))) begin
            cells[i] <= voteWord[i];
          end
          if (injEn && (injCopy == 2'(c)) && (rdAddr == ADDR_W'(i))) begin
            cells[i][injBit] <= injData[injBit];
          end
        end
      end
    end

    assign copyWord[c] = cells;
    assign needFix[c]  = (copyWord[c][scrubAddr] != voteWord[scrubAddr]);
  end

  assign scrubMismatch = |needFix;
  assign cfgOut        = voteWord;

  always_comb begin
    rdData = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (readLine[i]) rdData = rdData | voteWord[i];
    end
  end

  // R4
  rd_blank_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> (rdData == '0));

  // R7
  scrub_keeps_vote_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.scrubEn && !injEn) |=> $stable(cfgOut));

  // R3
  first_load_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.copyLoad[0] && !injEn) |=> $stable(cfgOut));

endmodule

// File: rtl/tmr_cfg_regfile.sv
module tmr_cfg_regfile
  import tmrCfgPkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16,
  localparam int DEPTH = 1 << ADDR_W,
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    wrEn,
  input  logic [ADDR_W-1:0]       wrAddr,
  input  logic [DATA_W-1:0]       wrData,
  output logic [DATA_W-1:0]       rdData,
  output logic                    busy,
  output logic [DEPTH*DATA_W-1:0] cfgOut,
  output logic                    scrubFix,
  input  logic                    injEn,
  input  logic [1:0]              injCopy,
  input  logic [BIT_W-1:0]        injBit
);

  ctrlStrobeT        strobe;
  logic [ADDR_W-1:0] loadAddr;
  logic [DATA_W-1:0] loadData;
  logic [ADDR_W-1:0] scrubAddr;
  logic              scrubMismatch;

  tmrCfgCtrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .wrEn         (wrEn),
    .wrAddr       (wrAddr),
    .wrData       (wrData),
    .scrubMismatch(scrubMismatch),
    .strobe       (strobe),
    .loadAddr     (loadAddr),
    .loadData     (loadData),
    .scrubAddr    (scrubAddr),
    .busy         (busy),
    .scrubFix     (scrubFix)
  );

  tmrCfgDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .BIT_W(BIT_W)) uData (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .loadAddr     (loadAddr),
    .loadData     (loadData),
    .scrubAddr    (scrubAddr),
    .rdAddr       (wrAddr),
    .wrEn         (wrEn),
    .injEn        (injEn),
    .injCopy      (injCopy),
    .injBit       (injBit),
    .injData      (wrData),
    .rdData       (rdData),
    .cfgOut       (cfgOut),
    .scrubMismatch(scrubMismatch)
  );

endmodule

// File: tb/sim_tmr_cfg_regfile.sv
module sim_tmr_cfg_regfile;

  logic         clk = 1'b0;
  logic         rstN;
  logic         wrEn;
  logic [4:0]   wrAddr;
  logic [15:0]  wrData;
  logic [15:0]  rdData;
  logic         busy;
  logic [511:0] cfgOut;
  logic         scrubFix;
  logic         injEn;
  logic [1:0]   injCopy;
  logic [3:0]   injBit;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 1'b0;
  logic [15:0] model [32];

  always #5 clk = ~clk;

  tmr_cfg_regfile u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdData(rdData), .busy(busy), .cfgOut(cfgOut), .scrubFix(scrubFix),
    .injEn(injEn), .injCopy(injCopy), .injBit(injBit)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] word(input int a);
    return cfgOut[a*16 +: 16];
  endfunction

  task automatic countFix(input int cycles, output int pulses);
    pulses = 0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      if (scrubFix) pulses++;
    end
  endtask

  task automatic testReset();
    rstN = 1'b0; wrEn = 1'b0; wrAddr = 5'd7; wrData = '0;
    injEn = 1'b0; injCopy = 2'd3; injBit = '0;
    for (int a = 0; a < 32; a++) model[a] = '0;
    repeat (3) @(negedge clk);
    #1;
    check("R1 busy in reset", 32'(busy), 32'd0);
    check("R1 cfgOut in reset", 32'(|cfgOut), 32'd0);
    check("R1 rdData in reset", 32'(rdData), 32'd0);
    check("R1 scrubFix in reset", 32'(scrubFix), 32'd0);
    // upset copy A of word 1, bit 0, on the first edge after release
    wrAddr = 5'd1; wrData = 16'h0001; injEn = 1'b1; injCopy = 2'd0; injBit = 4'd0;
    rstN = 1'b1;
    @(negedge clk);
    injEn = 1'b0; injCopy = 2'd3; wrData = '0;
    #1;
    check("R7 no fix while pointer at 0", 32'(scrubFix), 32'd0);
    check("R6 vote hides upset", 32'(word(1)), 32'd0);
    @(negedge clk);
    check("R7 fix when pointer reaches 1", 32'(scrubFix), 32'd1);
    @(negedge clk);
    check("R7 single pulse", 32'(scrubFix), 32'd0);
    check("R1 busy after release", 32'(busy), 32'd0);
  endtask

  task automatic doWrite(input logic [4:0] a, input logic [15:0] d);
    logic [15:0] old;
    old = model[a];
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    #1;
    check("R2 busy after accept", 32'(busy), 32'd1);
    check("R3 old value after accept", 32'(word(a)), 32'(old));
    @(negedge clk);
    check("R3 old value after copy A", 32'(word(a)), 32'(old));
    @(negedge clk);
    check("R3 new value after copy B", 32'(word(a)), 32'(d));
    check("R2 busy third cycle", 32'(busy), 32'd1);
    @(negedge clk);
    check("R2 busy drops", 32'(busy), 32'd0);
    check("R5 cfgOut word", 32'(word(a)), 32'(d));
    check("R4 rdData after write", 32'(rdData), 32'(d));
    model[a] = d;
  endtask

  task automatic testBusyIgnore();
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 5'd4; wrData = 16'hA5A5;
    @(negedge clk);
    wrAddr = 5'd9; wrData = 16'hFFFF;
    #1;
    check("R4 rdData blank while wrEn", 32'(rdData), 32'd0);
    @(negedge clk);
    wrEn = 1'b0;
    repeat (3) @(negedge clk);
    check("R2 busy clear", 32'(busy), 32'd0);
    check("R2 write while busy ignored", 32'(word(9)), 32'(model[9]));
    check("R2 accepted write landed", 32'(word(4)), 32'hA5A5);
    model[4] = 16'hA5A5;
  endtask

  task automatic testRead();
    for (int a = 0; a < 32; a += 5) begin
      @(negedge clk);
      wrAddr = 5'(a);
      #1;
      check("R4 read voted word", 32'(rdData), 32'(model[a]));
      check("R5 cfgOut word", 32'(word(a)), 32'(model[a]));
    end
  endtask

  task automatic injectOne(input logic [1:0] cp, input logic [4:0] a, input logic [3:0] b);
    @(negedge clk);
    wrAddr = a; wrData = model[a] ^ (16'h1 << b);
    injEn = 1'b1; injCopy = cp; injBit = b;
    @(negedge clk);
    injEn = 1'b0; injCopy = 2'd3; wrData = model[a];
    #1;
  endtask

  task automatic testInject();
    int pulses;
    injectOne(2'd0, 5'd3, 4'd5);
    check("R6 cfgOut unchanged after upset A", 32'(word(3)), 32'(model[3]));
    check("R6 rdData unchanged after upset A", 32'(rdData), 32'(model[3]));
    countFix(40, pulses);
    check("R7 one repair for upset A", 32'(pulses), 32'd1);
    injectOne(2'd1, 5'd3, 4'd5);
    check("R7 repaired A outvotes upset B", 32'(word(3)), 32'(model[3]));
    countFix(40, pulses);
    check("R7 one repair for upset B", 32'(pulses), 32'd1);
    injectOne(2'd2, 5'd30, 4'd15);
    check("R6 cfgOut unchanged after upset C", 32'(word(30)), 32'(model[30]));
    injectOne(2'd3, 5'd30, 4'd15);
    check("R6 copy select 3 touches nothing", 32'(word(30)), 32'(model[30]));
    countFix(40, pulses);
    check("R7 one repair for upset C", 32'(pulses), 32'd1);
  endtask

  task automatic testCleanWrite();
    int pulses;
    doWrite(5'd17, 16'h0F0F);
    countFix(40, pulses);
    check("R8 no repair after clean write", 32'(pulses), 32'd0);
    doWrite(5'd31, 16'h8001);
    doWrite(5'd0, 16'h7FFE);
    countFix(40, pulses);
    check("R8 no repair after boundary writes", 32'(pulses), 32'd0);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      nFails++;
      $display("FAIL all: watchdog expired, actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    testReset();
    doWrite(5'd3, 16'h1234);
    doWrite(5'd30, 16'hFFFF);
    doWrite(5'd3, 16'hBEEF);
    testBusyIgnore();
    testRead();
    testInject();
    testCleanWrite();
    testRead();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule